// File: doc/BRIEF.md
# Stack Pointer Push/Pop Engine

This block holds an 8-bit stack pointer and a 128-byte internal RAM. It carries out push and pop transfers between that RAM and a caller that supplies or consumes one byte at a time. A push first increments the pointer and then stores the byte at the new address, so the stack grows toward higher addresses. A pop reads the byte at the current address and then decrements the pointer. Software may also load the pointer with any 8-bit value. A push can take the pointer's own pre-increment value as its data.

The pointer can move past the last RAM byte, because it is 8 bits wide and the RAM ends at 7Fh. Pushes to such addresses are dropped and pops from them return zero. Both cases, and a request that asks for a push and a pop together, raise a one-cycle error pulse. Each request completes in one clock cycle.

Top module: `stack_engine`

## Requirements
- R1: After reset the pointer reads 07h, and both `pop_valid` and `err` are 0.
- R2: An accepted push (`push_req` high, `pop_req` low) adds one to the pointer and writes `push_data` at the incremented address. The new pointer is visible on the next cycle, so the first push after reset writes address 08h.
- R3: An accepted pop (`pop_req` high, `push_req` low) returns the byte at the current pointer on `pop_data`, with `pop_valid` high for exactly the next cycle. The pointer is then one lower. `pop_valid` is low in every other cycle.
- R4: A push whose incremented pointer is above 7Fh stores nothing and raises `err`. No RAM byte changes, but the pointer still advances. A push that lands exactly on 7Fh is stored without error.
- R5: Incrementing the pointer from FFh gives 00h, and decrementing from 00h gives FFh.
- R6: With `ptr_wr` high and no push or pop requested, the pointer takes `ptr_wdata` on the next cycle. If a push or pop is requested in the same cycle, `ptr_wr` has no effect.
- R7: With `push_self` high, a push stores the pointer value from before the increment instead of `push_data`.
- R8: A push and a pop requested in the same cycle are both rejected. The pointer and RAM are unchanged, `pop_valid` stays low, and `err` is raised.
- R9: A pop with the pointer above 7Fh returns 00h with `pop_valid`, raises `err`, and still decrements the pointer.
- R10: `err` is high only in the cycle after a request covered by R4, R8 or R9, and low after every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Push request for this cycle |
| push_self | input | 1 | Push the current pointer value instead of push_data |
| push_data | input | 8 | Byte to push |
| pop_req | input | 1 | Pop request for this cycle |
| ptr_wr | input | 1 | Load the pointer directly |
| ptr_wdata | input | 8 | Value for the pointer load |
| pop_data | output | 8 | Byte returned by the last pop |
| pop_valid | output | 1 | One-cycle strobe marking pop_data |
| sp | output | 8 | Current stack pointer |
| err | output | 1 | One-cycle error pulse |

## Verification
A wrong pointer shows on `sp` in the cycle after the request that caused it. It also shows later as a wrong byte on the next pop, because every store and read uses that pointer. A RAM that wraps out-of-range addresses onto low ones stays hidden until a pop from address 00h after an out-of-range push; the bench places that pop directly after the push sequence. Error-flag and strobe faults appear in the single cycle after the request, so each operation is checked in the cycle that follows it.

// File: rtl/stack_engine.sv
module stack_engine #(
  parameter int DATA_W    = 8,
  parameter int PTR_W     = 8,
  parameter int RAM_DEPTH = 128,
  parameter int RESET_PTR = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              push_self,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  input  logic              ptr_wr,
  input  logic [PTR_W-1:0]  ptr_wdata,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_valid,
  output logic [PTR_W-1:0]  sp,
  output logic              err
);
  localparam int ADDR_W = $clog2(RAM_DEPTH);
  localparam logic [PTR_W-1:0] TOP_ADDR = PTR_W'(RAM_DEPTH - 1);

  logic [DATA_W-1:0] ram [RAM_DEPTH];

  wire both_req = push_req & pop_req;
  wire do_push  = push_req & ~pop_req;
  wire do_pop   = pop_req & ~push_req;
  wire do_load  = ptr_wr & ~push_req & ~pop_req;

  wire [PTR_W-1:0] sp_up   = sp + 1'b1;
  wire [PTR_W-1:0] sp_down = sp - 1'b1;
  wire push_in_ram = sp_up <= TOP_ADDR;
  wire pop_in_ram  = sp <= TOP_ADDR;

  wire [DATA_W-1:0] push_byte = push_self ? DATA_W'(sp) : push_data;

  always_ff @(posedge clk) begin
    if (!rst_n)       sp <= PTR_W'(RESET_PTR);
    else if (do_push) sp <= sp_up;
    else if (do_pop)  sp <= sp_down;
    else if (do_load) sp <= ptr_wdata;
  end

  always_ff @(posedge clk) begin
    if (do_push && push_in_ram)
      ram[sp_up[ADDR_W-1:0]] <= push_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pop_data  <= '0;
      pop_valid <= 1'b0;
      err       <= 1'b0;
    end else begin
      pop_valid <= do_pop;
      err       <= both_req | (do_push & ~push_in_ram) | (do_pop & ~pop_in_ram);
      if (do_pop)
        pop_data <= pop_in_ram ? ram[sp[ADDR_W-1:0]] : '0;
    end
  end

  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> sp == PTR_W'($past(sp) + 1'b1));

  assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> pop_valid && sp == PTR_W'($past(sp) - 1'b1));

  assert_strobe_only_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !do_pop |=> !pop_valid);

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> sp == $past(ptr_wdata));

  assert_conflict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    both_req |=> err && !pop_valid && $stable(sp));

  assert_high_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && sp > TOP_ADDR) |=> pop_data == '0 && err);

  assert_quiet_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_req && !pop_req) |=> !err);
endmodule

// File: tb/test_stack_engine.sv
module test_stack_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_req = 1'b0, push_self = 1'b0, pop_req = 1'b0, ptr_wr = 1'b0;
  logic [7:0] push_data = '0, ptr_wdata = '0;
  logic [7:0] pop_data, sp;
  logic pop_valid, err;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  logic [7:0] m_sp;
  logic [7:0] m_ram [128];

  always #2 clk = ~clk;

  stack_engine i_stack_engine (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_self(push_self),
    .push_data(push_data), .pop_req(pop_req), .ptr_wr(ptr_wr),
    .ptr_wdata(ptr_wdata), .pop_data(pop_data), .pop_valid(pop_valid),
    .sp(sp), .err(err)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pop_valid) begin
      if (exp_q.size() == 0) begin
        compared++;
        mismatched++;
        $display("FAIL R3: actual strobe with data %02h expected no strobe", pop_data);
      end else begin
        check("R3 pop data", pop_data, exp_q.pop_front());
      end
    end
  end

  task automatic op(input string req, input bit pu, input bit self_b, input bit po,
                    input bit wr, input logic [7:0] d);
    logic e;
    logic [7:0] nx;
    e = 1'b0;
    if (pu && po) e = 1'b1;
    else if (pu) begin
      nx = m_sp + 8'd1;
      if (nx <= 8'h7F) m_ram[nx[6:0]] = self_b ? m_sp : d;
      else e = 1'b1;
      m_sp = nx;
    end else if (po) begin
      exp_q.push_back(m_sp <= 8'h7F ? m_ram[m_sp[6:0]] : 8'h00);
      e = m_sp > 8'h7F;
      m_sp = m_sp - 8'd1;
    end else if (wr) m_sp = d;
    push_req = pu; push_self = self_b; pop_req = po; ptr_wr = wr;
    push_data = d; ptr_wdata = d;
    @(negedge clk);
    push_req = 0; push_self = 0; pop_req = 0; ptr_wr = 0;
    check({req, " sp"}, sp, m_sp);
    check({req, " err R10"}, {7'd0, err}, {7'd0, e});
    check({req, " strobe R3"}, {7'd0, pop_valid}, {7'd0, po && !pu});
  endtask

  initial begin
    m_sp = 8'h07;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 sp", sp, 8'h07);
    check("R1 strobe", {7'd0, pop_valid}, 8'd0);
    check("R1 err", {7'd0, err}, 8'd0);
    op("R2", 1, 0, 0, 0, 8'hA1);
    check("R2 first push at 08", sp, 8'h08);
    op("R2", 1, 0, 0, 0, 8'hB2);
    op("R3", 0, 0, 1, 0, 8'h00);
    op("R3", 0, 0, 1, 0, 8'h00);
    op("R6", 0, 0, 0, 1, 8'h30);
    op("R2", 1, 0, 0, 0, 8'hAC);
    op("R2", 1, 0, 0, 0, 8'hAC);
    op("R3", 0, 0, 1, 0, 8'h00);
    op("R3", 0, 0, 1, 0, 8'h00);
    op("R7", 1, 1, 0, 0, 8'hEE);
    op("R7", 0, 0, 1, 0, 8'h00);
    op("R8", 1, 0, 1, 0, 8'h99);
    op("R6", 1, 0, 0, 1, 8'h44);
    op("R6", 0, 0, 1, 1, 8'h55);
    op("R5", 0, 0, 0, 1, 8'hFF);
    op("R5", 1, 0, 0, 0, 8'h5A);
    op("R5", 0, 0, 1, 0, 8'h00);
    op("R4", 0, 0, 0, 1, 8'h7F);
    op("R4", 1, 0, 0, 0, 8'h66);
    op("R4", 1, 0, 0, 0, 8'h77);
    op("R4", 0, 0, 0, 1, 8'h00);
    op("R4", 0, 0, 1, 0, 8'h00);
    op("R4", 0, 0, 0, 1, 8'h7E);
    op("R4", 1, 0, 0, 0, 8'h11);
    op("R4", 0, 0, 1, 0, 8'h00);
    op("R9", 0, 0, 0, 1, 8'h85);
    op("R9", 0, 0, 1, 0, 8'h00);
    op("R10", 0, 0, 0, 0, 8'h00);
    op("R10", 0, 0, 0, 0, 8'h00);
    check("R3 all pops returned", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule